// File: doc/BRIEF.md
# Four-Port Arbiter Tree

This block shares one server among four requesters. Each requester and the server use a four-phase request/acknowledge handshake. The block is built as a two-level tree of identical two-input ring arbiters. Requesters 1 and 2 meet in one leaf node, and requesters 3 and 4 meet in the other. The two leaf outputs meet in a root node, and the root drives the server handshake. Every node opens a decide window of a fixed number of cycles before it picks a winner. It then keeps its connection locked until the winning input has returned to zero and the acknowledge from above has dropped.

Each outer port has a small dismiss buffer in front of the tree. When the server acknowledges, the buffer withdraws its inner request at once and raises the acknowledge to its port. The server therefore begins its reset phase without waiting for the requester to drop its request. The late release from the requester is simply absorbed.

Ring arbitration runs at both levels, so a fully loaded tree serves the ports in the interleaved order 1, 3, 2, 4. While one branch holds the server, the other leaf node runs its own decide window. As a result the root has a decided request waiting when the server frees up.

Top module: `arb_tree4`

## Requirements
- R1: While reset is held and on the first cycle after it, every port acknowledge is low and the server request is low.
- R2: Every rising request on a port produces exactly one server cycle and exactly one acknowledge pulse on that port. No server cycle occurs without a port request behind it.
- R3: A port acknowledge rises only while that port's request is high, and only in the cycle after the server's acknowledge has been routed to that port.
- R4: From reset, simultaneous requests are resolved with the branch of ports 1 and 2 ahead of the branch of ports 3 and 4, and with the lower-numbered port ahead within a branch. Port n is bit n-1 of the port vectors.
- R5: With all four ports requesting continuously, service follows the repeating order 1, 3, 2, 4.
- R6: Each two-input node gives lowest priority to the input it served last. For example, simultaneous requests on ports 1, 2 and 4 are served as 1, 4, 2, and requests on ports 2, 3 and 4 are served as 2, 3, 4.
- R7: Once the server acknowledges a port, that port's inner request is withdrawn and the server reset phase completes even if the port keeps its request high. The port acknowledge then stays high until the port drops its request. A held request neither causes a second service nor blocks other ports.
- R8: The server request rises only while the server acknowledge is low.
- R9: Under full load, the server request rises again no more than DECIDE_CYC+2 cycles after the server acknowledge falls. The other branch has already decided during the previous service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_req | input | NPORTS | Four-phase request from each requester; bit n-1 is port n |
| port_ack | output | NPORTS | Four-phase acknowledge to each requester |
| srv_req | output | 1 | Request to the shared server |
| srv_ack | input | 1 | Acknowledge from the shared server |

## Verification
The bench goes after the service order under every mix of simultaneous requests from reset. A node that failed to rotate its ring pointer, or that reversed its tie rule, would serve 1, 2, 4 instead of 1, 4, 2, or would serve the 3/4 branch first. Under full load, the bench times the gap from a server acknowledge falling to the next server request. A tree whose leaf decided only after the root had moved on would add a whole decide window to that gap. A port that holds its request after being served must neither lock the server nor earn a second cycle, which a missing dismiss buffer would cause. A scoreboard flags any acknowledge sent to a port that is not requesting, and any mismatch between server cycles and port requests.

// File: rtl/arb_tree_pkg.sv
package arb_tree_pkg;

    // State of a two-input ring node
    typedef enum logic [1:0] {
        N_IDLE   = 2'd0,
        N_DECIDE = 2'd1,
        N_BUSY   = 2'd2
    } node_st_e;

    // State of a dismiss buffer in front of an outer port
    typedef enum logic [1:0] {
        B_IDLE = 2'd0,
        B_WAIT = 2'd1,
        B_DONE = 2'd2
    } buf_st_e;

endpackage

// File: rtl/ring_node.sv
module ring_node
    import arb_tree_pkg::*;
#(
    parameter int NIN        = 2,
    parameter int DECIDE_CYC = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] in_req,
    output logic [NIN-1:0] in_ack,
    output logic           out_req,
    input  logic           out_ack
);

    localparam int IW = (NIN > 1) ? $clog2(NIN) : 1;
    localparam int CW = (DECIDE_CYC > 1) ? $clog2(DECIDE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DECIDE_CYC - 1);
    localparam logic [IW-1:0] WIN_INIT = IW'(NIN - 1);

    typedef struct packed {
        node_st_e      st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] win;
        logic [IW-1:0] last;
    } node_t;

    node_t q, d;

    // Scan from the input after the last served one; the nearest requester wins.
    function automatic logic [IW-1:0] ring_pick(input logic [NIN-1:0] r,
                                                input logic [IW-1:0]  lst);
        logic [IW-1:0] sel;
        int            idx;
        sel = lst;
        for (int k = NIN; k >= 1; k--) begin
            idx = int'(lst) + k;
            if (idx >= NIN) idx = idx - NIN;
            if (r[idx]) sel = IW'(idx);
        end
        return sel;
    endfunction

    always_comb begin
        d = q;
        case (q.st)
            N_IDLE: begin
                if (|in_req) begin
                    d.st  = N_DECIDE;
                    d.cnt = '0;
                end
            end
            N_DECIDE: begin
                if (q.cnt == CNT_LAST) begin
                    d.win  = ring_pick(in_req, q.last);
                    d.last = ring_pick(in_req, q.last);
                    d.st   = N_BUSY;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            N_BUSY: begin
                // Connection stays locked until the input resets and the server has reset
                if (!in_req[q.win] && !out_ack) d.st = N_IDLE;
            end
            default: d.st = N_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= N_IDLE;
            q.cnt  <= '0;
            q.win  <= WIN_INIT;
            q.last <= WIN_INIT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        out_req = (q.st == N_BUSY) && in_req[q.win];
        in_ack  = '0;
        if (q.st == N_BUSY) in_ack[q.win] = out_ack;
    end

endmodule

// File: rtl/port_dismiss.sv
module port_dismiss
    import arb_tree_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic p_req,
    output logic p_ack,
    output logic i_req,
    input  logic i_ack
);

    typedef struct packed {
        buf_st_e st;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            B_IDLE: if (p_req) d.st = B_WAIT;
            B_WAIT: if (i_ack) d.st = B_DONE;
            B_DONE: if (!i_ack && !p_req) d.st = B_IDLE;
            default: d.st = B_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.st <= B_IDLE;
        else        q <= d;
    end

    assign i_req = (q.st == B_WAIT);
    assign p_ack = (q.st == B_DONE);

endmodule

// File: rtl/arb_tree4.sv
module arb_tree4 #(
    parameter  int LEAF_FANIN = 2,
    parameter  int ROOT_FANIN = 2,
    parameter  int DECIDE_CYC = 4,
    localparam int NPORTS     = LEAF_FANIN * ROOT_FANIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] port_req,
    output logic [NPORTS-1:0] port_ack,
    output logic              srv_req,
    input  logic              srv_ack
);

    logic [NPORTS-1:0]     inner_req;
    logic [NPORTS-1:0]     inner_ack;
    logic [ROOT_FANIN-1:0] leaf_req;
    logic [ROOT_FANIN-1:0] leaf_ack;

    for (genvar p = 0; p < NPORTS; p++) begin : g_buf
        port_dismiss u_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .p_req (port_req[p]),
            .p_ack (port_ack[p]),
            .i_req (inner_req[p]),
            .i_ack (inner_ack[p])
        );
    end

    for (genvar s = 0; s < ROOT_FANIN; s++) begin : g_leaf
        ring_node #(
            .NIN        (LEAF_FANIN),
            .DECIDE_CYC (DECIDE_CYC)
        ) u_leaf (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_req  (inner_req[s*LEAF_FANIN +: LEAF_FANIN]),
            .in_ack  (inner_ack[s*LEAF_FANIN +: LEAF_FANIN]),
            .out_req (leaf_req[s]),
            .out_ack (leaf_ack[s])
        );
    end

    ring_node #(
        .NIN        (ROOT_FANIN),
        .DECIDE_CYC (DECIDE_CYC)
    ) u_root (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (leaf_req),
        .in_ack  (leaf_ack),
        .out_req (srv_req),
        .out_ack (srv_ack)
    );

endmodule

// File: rtl/arb_tree4_chk.sv
module arb_tree4_chk #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] port_req,
    input logic [NP-1:0] port_ack,
    input logic          srv_req,
    input logic          srv_ack,
    input logic [NP-1:0] inner_req,
    input logic [NP-1:0] inner_ack
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (port_ack == '0 && !srv_req)); // R1

    AST_ONE_INNER_ACK: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(inner_ack)); // R2

    AST_SRV_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(srv_req) |-> !srv_ack); // R8

    for (genvar i = 0; i < NP; i++) begin : g_port
        AST_ACK_FROM_INNER: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_ack[i]) |-> $past(inner_ack[i])); // R3

        AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (port_ack[i] && port_req[i]) |=> port_ack[i]); // R7

        AST_DISMISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_ack[i]) |-> !inner_req[i]); // R7
    end

endmodule

bind arb_tree4 arb_tree4_chk #(.NP(NPORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_req  (port_req),
    .port_ack  (port_ack),
    .srv_req   (srv_req),
    .srv_ack   (srv_ack),
    .inner_req (inner_req),
    .inner_ack (inner_ack)
);

// File: tb/arb_tree4_tb.sv
module arb_tree4_tb;

    localparam int DEC  = 4;
    localparam int NVEC = 12;

    // [19:16] request mask (bit n-1 = port n), [15:0] expected order, first port in top nibble
    localparam logic [19:0] VEC [NVEC] = '{
        {4'b1111, 16'h1324}, {4'b0101, 16'h1300}, {4'b0011, 16'h1200},
        {4'b1010, 16'h2400}, {4'b1100, 16'h3400}, {4'b0111, 16'h1320},
        {4'b1110, 16'h2340}, {4'b1101, 16'h1340}, {4'b1011, 16'h1420},
        {4'b0100, 16'h3000}, {4'b1000, 16'h4000}, {4'b1001, 16'h1400}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] port_req = '0;
    logic [3:0] port_ack;
    logic       srv_req;
    logic       srv_ack = 1'b0;

    always #5 clk = ~clk;

    arb_tree4 #(.DECIDE_CYC(DEC)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_req (port_req),
        .port_ack (port_ack),
        .srv_req  (srv_req),
        .srv_ack  (srv_ack)
    );

    int total = 0;
    int bad   = 0;

    logic [3:0] pend = '0, cont = '0, hold = '0;
    int   log_q [64];
    int   log_n = 0;
    int   srv_cnt = 0;
    int   gap = 0;
    logic gap_arm = 1'b0, gap_chk = 1'b0;
    logic [3:0] ack_prev = '0;
    logic srv_req_prev = 1'b0, srv_ack_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Requester model: four-phase, one-shot (pend), continuous (cont), or holding after ack (hold)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                port_req = '0;
            end else begin
                for (int i = 0; i < 4; i++) begin
                    if (port_req[i] && port_ack[i] && !hold[i]) begin
                        port_req[i] = 1'b0;
                    end else if (!port_req[i] && !port_ack[i] && (pend[i] || cont[i])) begin
                        port_req[i] = 1'b1;
                        pend[i] = 1'b0;
                    end
                end
            end
        end
    end

    // Server model with randomized busy time and reset latency
    initial begin
        int cnt;
        int stt;
        cnt = 0;
        stt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                srv_ack = 1'b0;
                stt = 0;
            end else begin
                case (stt)
                    0: if (srv_req) begin cnt = int'($urandom_range(3, 10)); stt = 1; end
                    1: if (cnt == 0) begin srv_ack = 1'b1; stt = 2; end else cnt--;
                    2: if (!srv_req) begin cnt = int'($urandom_range(0, 3)); stt = 3; end
                    default: if (cnt == 0) begin srv_ack = 1'b0; stt = 0; end else cnt--;
                endcase
            end
        end
    end

    // Monitor and scoreboard, sampled just after the active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                for (int i = 0; i < 4; i++) begin
                    if (port_ack[i] && !ack_prev[i]) begin
                        if (log_n < 64) log_q[log_n] = i + 1;
                        log_n++;
                        chk(port_req[i], "R3 ack to a requesting port", int'(port_req[i]), 1);
                    end
                end
                if (gap_arm) gap++;
                if (srv_req && !srv_req_prev) begin
                    srv_cnt++;
                    chk(!srv_ack, "R8 server request while ack low", int'(srv_ack), 0);
                    if (gap_chk && gap_arm)
                        chk(gap <= DEC + 2, "R9 overlapped decide gap", gap, DEC + 2);
                    gap_arm = 1'b0;
                end
                if (!srv_ack && srv_ack_prev) begin
                    gap_arm = 1'b1;
                    gap = 0;
                end
            end else begin
                gap_arm = 1'b0;
            end
            ack_prev     = port_ack;
            srv_req_prev = srv_req;
            srv_ack_prev = srv_ack;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        pend = '0;
        cont = '0;
        hold = '0;
        gap_chk = 1'b0;
        repeat (3) @(posedge clk);
        log_n = 0;
        srv_cnt = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_idle(input int n_exp, output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            @(posedge clk);
            #2;
            if (log_n >= n_exp && port_req == '0 && port_ack == '0 && !srv_req && !srv_ack) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        bit ok;
        do_reset();
        @(negedge clk);
        chk(port_ack == '0, "R1 port acks low after reset", int'(port_ack), 0);
        chk(!srv_req, "R1 server request low after reset", int'(srv_req), 0);

        // Table walk: simultaneous request mixes from reset
        for (int v = 0; v < NVEC; v++) begin
            int n;
            do_reset();
            n = $countones(VEC[v][19:16]);
            @(posedge clk);
            pend = VEC[v][19:16];
            wait_idle(n, ok);
            chk(ok, "R2 burst drained", int'(ok), 1);
            chk(log_n == n, "R2 one port ack per request", log_n, n);
            chk(srv_cnt == n, "R2 one server cycle per request", srv_cnt, n);
            for (int k = 0; k < n; k++) begin
                int e;
                e = int'(VEC[v][15 - 4*k -: 4]);
                chk(log_q[k] == e, "R4 R6 service order", log_q[k], e);
            end
        end

        // Full load: interleaved order and overlapped decide
        do_reset();
        @(posedge clk);
        gap_chk = 1'b1;
        cont = 4'hF;
        for (int c = 0; c < 5000 && log_n < 16; c++) @(posedge clk);
        gap_chk = 1'b0;
        cont = '0;
        wait_idle(16, ok);
        chk(ok, "R5 full load reached 16 services", log_n, 16);
        for (int k = 0; k < 16; k++) begin
            int e;
            e = (k % 4 == 0) ? 1 : (k % 4 == 1) ? 3 : (k % 4 == 2) ? 2 : 4;
            chk(log_q[k] == e, "R5 full load order", log_q[k], e);
        end
        chk(srv_cnt == log_n, "R2 server cycles match acks", srv_cnt, log_n);

        // Auto-dismiss: port 1 holds its request after service
        do_reset();
        @(posedge clk);
        hold = 4'b0001;
        pend = 4'b0001;
        for (int c = 0; c < 2000 && !port_ack[0]; c++) @(posedge clk);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(!srv_req && !srv_ack, "R7 server reset without port release", int'({srv_req, srv_ack}), 0);
        chk(port_ack[0], "R7 ack held while request held", int'(port_ack[0]), 1);
        chk(srv_cnt == 1, "R7 no second service", srv_cnt, 1);
        @(posedge clk);
        pend = 4'b0100;
        for (int c = 0; c < 2000 && !port_ack[2]; c++) @(posedge clk);
        @(negedge clk);
        chk(port_ack[2], "R7 held port does not block port 3", int'(port_ack[2]), 1);
        chk(srv_cnt == 2, "R7 two services total", srv_cnt, 2);
        @(posedge clk);
        hold = '0;
        wait_idle(2, ok);
        chk(ok && port_ack == '0, "R7 ack drops after release", int'(port_ack), 0);
        chk(srv_cnt == 2, "R2 no extra service after release", srv_cnt, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL watchdog R2 actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule